// File: doc/BRIEF.md
# Word-Addressed GPIO Register Block

This block is a 32-line general-purpose I/O peripheral that sits on a simple single-cycle register bus. It stores three words: a line-level word, a direction word (a one makes the line an output) and a spare scratch word. Two write-only ports change the level word. The set port ORs bits in and the clear port clears bits. Each of these writes is gated by the direction word.

The gating works on the whole word. A set or clear write that shares at least one bit with the output lines is applied with every bit written, including bits of input lines. A write that shares no bit with the output lines is dropped completely, and a one-cycle reject pulse flags it. The pads are driven with the level word masked by the direction word, and the output enables follow the direction word. Three edge-detect slots are decoded but do nothing. Nine interrupt lines exist and are held low.

Requests carry an address, a write flag, 32-bit write data and a valid strobe. Read data is registered and appears one cycle after the read request. The read data holds its value until the next read.

Top module: `gpio_regblk`

## Requirements
- R1: After reset the level, direction and scratch words are zero, so pad_out, pad_oe, rsp_rdata and wr_reject are all zero.
- R2: A write to byte offset 0x04 loads the direction word. From the next cycle pad_oe equals that word, and a read of 0x04 returns it.
- R3: A write to offset 0x08 whose data shares a bit with the direction word sets every written bit in the level word: level becomes level OR data, including bits of input lines.
- R4: A write to offset 0x0C whose data shares a bit with the direction word clears every written bit: level becomes level AND NOT data.
- R5: A set or clear write whose data shares no bit with the direction word leaves the level word unchanged. wr_reject is high for exactly the cycle after such a write and low after every other request.
- R6: A read request returns, on rsp_rdata in the following cycle, the level word for offset 0x00, the direction word for 0x04, the scratch word for 0x20, and zero for any other address, including misaligned ones. rsp_rdata holds its value when there is no read.
- R7: A write to offset 0x20 loads the scratch word, which has no effect on the pads.
- R8: Writes to the edge slots 0x10, 0x14 and 0x18, and writes to any undecoded or misaligned address, change no stored word.
- R9: pad_out always equals the level word ANDed with the direction word.
- R10: The eight per-line interrupt outputs and the combined interrupt output stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data, valid the cycle after a read |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| wr_reject | output | 1 | Pulse marking a dropped set or clear write |
| irq_line | output | 8 | Per-line interrupt outputs (held low) |
| irq_comb | output | 1 | Combined interrupt output (held low) |

## Verification
The assertions assume that every access is a full 32-bit word and that req_write and req_addr are meaningful only while req_valid is high. They also assume that the bus stays quiet while reset is asserted, so the past values they sample always come from a real request. The stimulus issues one request per clock, raising valid only after reset has been released. It draws addresses from the decoded offsets, the edge slots and several unmapped or misaligned values. For some set and clear data it masks away the output bits on purpose, so that both the accepted and the dropped branch occur often.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Byte offsets of the decoded slots
    localparam int unsigned OFS_LEVEL = 32'h00;
    localparam int unsigned OFS_DIR   = 32'h04;
    localparam int unsigned OFS_SET   = 32'h08;
    localparam int unsigned OFS_CLR   = 32'h0C;
    localparam int unsigned OFS_RISE  = 32'h10;
    localparam int unsigned OFS_FALL  = 32'h14;
    localparam int unsigned OFS_EVT   = 32'h18;
    localparam int unsigned OFS_SCR   = 32'h20;

    // One-hot slot select produced by the decoder
    typedef struct packed {
        logic level;
        logic dir;
        logic set;
        logic clr;
        logic edg;
        logic scr;
    } gpio_sel_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_sel_t         sel
);

    always_comb begin
        sel       = '0;
        sel.level = (addr == ADDR_W'(OFS_LEVEL));
        sel.dir   = (addr == ADDR_W'(OFS_DIR));
        sel.set   = (addr == ADDR_W'(OFS_SET));
        sel.clr   = (addr == ADDR_W'(OFS_CLR));
        sel.edg   = (addr == ADDR_W'(OFS_RISE)) ||
                    (addr == ADDR_W'(OFS_FALL)) ||
                    (addr == ADDR_W'(OFS_EVT));
        sel.scr   = (addr == ADDR_W'(OFS_SCR));
    end

endmodule

// File: rtl/gpio_store.sv
module gpio_store
    import gpio_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  gpio_sel_t         sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] level,
    output logic [DATA_W-1:0] dir,
    output logic [DATA_W-1:0] rdata,
    output logic              reject
);

    typedef struct packed {
        logic [DATA_W-1:0] level;
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] scr;
        logic [DATA_W-1:0] rdata;
        logic              reject;
    } store_t;

    store_t st_d, st_q;
    logic   wr_en, rd_en, hits_out;

    always_comb begin
        wr_en    = valid && write;
        rd_en    = valid && !write;
        hits_out = |(st_q.dir & wdata);
        st_d        = st_q;
        st_d.reject = 1'b0;
        if (wr_en) begin
            if (sel.dir) st_d.dir = wdata;
            if (sel.scr) st_d.scr = wdata;
            if (sel.set) begin
                if (hits_out) st_d.level = st_q.level | wdata;
                else          st_d.reject = 1'b1;
            end
            if (sel.clr) begin
                if (hits_out) st_d.level = st_q.level & ~wdata;
                else          st_d.reject = 1'b1;
            end
        end
        if (rd_en) begin
            if (sel.level)    st_d.rdata = st_q.level;
            else if (sel.dir) st_d.rdata = st_q.dir;
            else if (sel.scr) st_d.rdata = st_q.scr;
            else              st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level  = st_q.level;
    assign dir    = st_q.dir;
    assign rdata  = st_q.rdata;
    assign reject = st_q.reject;

    AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && sel.set && |(dir & wdata)) |=> (level == ($past(level) | $past(wdata)))); // R3

    AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && sel.clr && |(dir & wdata)) |=> (level == ($past(level) & ~$past(wdata)))); // R4

    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && (sel.set || sel.clr) && !(|(dir & wdata))) |=> ($stable(level) && reject)); // R5

    AST_NO_SPURIOUS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && write && (sel.set || sel.clr)) |=> !reject); // R5

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && sel.dir) |=> (dir == $past(wdata))); // R2

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !write && !(sel.level || sel.dir || sel.scr)) |=> (rdata == '0)); // R6

    AST_EDGE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && sel.edg) |=> ($stable(level) && $stable(dir) && $stable(st_q.scr))); // R8

endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
    import gpio_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned LINE_IRQ = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [DATA_W-1:0]   pad_out,
    output logic [DATA_W-1:0]   pad_oe,
    output logic                wr_reject,
    output logic [LINE_IRQ-1:0] irq_line,
    output logic                irq_comb
);

    gpio_sel_t         sel;
    logic [DATA_W-1:0] level, dir;

    gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    gpio_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (req_valid),
        .write  (req_write),
        .sel    (sel),
        .wdata  (req_wdata),
        .level  (level),
        .dir    (dir),
        .rdata  (rsp_rdata),
        .reject (wr_reject)
    );

    assign pad_out = level & dir;
    assign pad_oe  = dir;

    // Interrupt lines exist but carry no source
    for (genvar i = 0; i < LINE_IRQ; i++) begin : g_irq
        assign irq_line[i] = 1'b0;
    end
    assign irq_comb = 1'b0;

    AST_PAD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0); // R9

endmodule

// File: tb/gpio_regblk_test.sv
module gpio_regblk_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata, pad_out, pad_oe;
    logic        wr_reject, irq_comb;
    logic [7:0]  irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_level = '0, m_dir = '0, m_scr = '0;

    always #10 clk = ~clk;

    gpio_regblk uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe), .wr_reject(wr_reject),
        .irq_line(irq_line), .irq_comb(irq_comb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_level;
            8'h04:   return m_dir;
            8'h20:   return m_scr;
            default: return 32'h0;
        endcase
    endfunction

    // One request; checks outputs the cycle after it
    task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] exp_rd;
        bit          exp_rej;
        logic [31:0] prev_rd;
        prev_rd = rsp_rdata;
        exp_rej = 1'b0;
        exp_rd  = wr ? prev_rd : exp_read(a);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (wr) begin
            case (a)
                8'h04: m_dir = d;
                8'h20: m_scr = d;
                8'h08: if ((m_dir & d) != 0) m_level = m_level | d; else exp_rej = 1'b1;
                8'h0C: if ((m_dir & d) != 0) m_level = m_level & ~d; else exp_rej = 1'b1;
                default: ;
            endcase
        end
        check("R5 reject", {31'b0, wr_reject}, {31'b0, exp_rej});
        check("R9 pad_out", pad_out, m_level & m_dir);
        check("R2 pad_oe", pad_oe, m_dir);
        check("R6 rdata", rsp_rdata, exp_rd);
        check("R10 irq", {23'b0, irq_comb, irq_line}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [12];
        void'($urandom(32'h5eed));
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20,
                  8'h1C, 8'h24, 8'h05, 8'hFC};
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 level/pad", pad_out, 32'h0);
        check("R1 oe", pad_oe, 32'h0);
        check("R1 rdata", rsp_rdata, 32'h0);
        check("R1 reject", {31'b0, wr_reject}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        access(0, 8'h00, 0);            // R1 level reads zero
        access(0, 8'h20, 0);            // R1 scratch reads zero
        // R5: set with no output lines is dropped
        access(1, 8'h08, 32'hFFFF_FFFF);
        access(0, 8'h00, 0);
        // R2 direction, R3 set applies input bits too
        access(1, 8'h04, 32'h0000_0001);
        access(1, 8'h08, 32'h0000_0003);
        access(0, 8'h00, 0);            // level 0x3, pad_out 0x1
        // R5 set missing the output bit
        access(1, 8'h08, 32'h0000_0100);
        // R4 clear with overlap clears all written bits
        access(1, 8'h04, 32'h0000_00F0);
        access(1, 8'h08, 32'h0000_FF10);
        access(1, 8'h0C, 32'h0000_0F13);
        access(0, 8'h00, 0);
        access(1, 8'h0C, 32'h0000_F000); // R5 clear dropped
        // R7 scratch, R8 edge slots and misaligned
        access(1, 8'h20, 32'hDEAD_BEEF);
        access(0, 8'h20, 0);
        access(1, 8'h10, 32'hFFFF_FFFF);
        access(1, 8'h14, 32'hFFFF_FFFF);
        access(1, 8'h18, 32'hFFFF_FFFF);
        access(1, 8'h05, 32'h1234_5678);
        access(0, 8'h04, 0);
        access(0, 8'h18, 0);             // R6 unmapped reads zero
        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            bit          wr;
            a  = addrs[$urandom_range(0, 11)];
            d  = $urandom;
            wr = $urandom_range(0, 1);
            if ((a == 8'h08 || a == 8'h0C) && $urandom_range(0, 2) == 0) d = d & ~m_dir;
            if (a == 8'h04 && $urandom_range(0, 3) == 0) d = 32'h0;
            access(wr, a, d);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule